// File: doc/BRIEF.md
# Lagged-Sample Match Counter

This block sits behind a sampler that turns a pair of free-running oscillators into a raw bit stream, with no decimation between them. Every accepted bit is pushed into a delay line whose length M is chosen per run. Each new bit is compared with the bit that entered the line M accepted samples earlier. The block counts the equal pairs over a window of N consecutive comparisons. When a window closes it puts the count on its output together with a one-cycle strobe. After K windows the run stops and a done flag rises. A downstream statistics unit takes the per-window counts and works out the mean and variance that estimate the oscillator jitter.

A run begins with a start pulse. The pulse latches M, N and K, empties the delay line and clears the window position, the window index and the done flag. No comparison is made until M samples have entered the line since the start. Samples presented while no run is active are ignored.

Top module: `lag_match_counter`

## Requirements
- R1: After reset, `count_stb`, `run_done` and `match_count` are all 0. No run is active until `start` is pulsed.
- R2: After a start, the first M accepted samples only fill the delay line. A window's first comparison uses sample M+1, counting samples from 1 after the start.
- R3: Each comparison pairs the incoming bit with the bit accepted exactly M samples before it. It counts as a match when the two bits are equal.
- R4: A cycle with `sample_vld` low neither shifts the delay line nor advances the window, so gaps in the stream do not change the lag.
- R5: After the N-th comparison of a window, `count_stb` is high for exactly one cycle, on the cycle that follows that sample. In that cycle `match_count` holds the number of matches in the window, between 0 and N inclusive. The next window starts counting from zero.
- R6: `run_done` rises in the same cycle as the strobe of the K-th window and stays high until the next `start` or reset. While it is high, samples produce no strobe.
- R7: `start` takes priority over a sample in the same cycle, and that sample is dropped. One cycle after a start, `run_done` is 0. A start that arrives during a run abandons it and begins again with an empty line.
- R8: M, N and K are captured when `start` is pulsed. Changing `lag_len`, `win_len` or `win_total` during a run has no effect on that run.
- R9: A configuration value of 0 is treated as 1. A value of `lag_len` above MAX_LAG is treated as MAX_LAG. The same limits apply to `win_len` with MAX_WIN and to `win_total` with MAX_RUN.
- R10: `match_count` is ceil(log2(MAX_WIN+1)) bits wide and reports N for a window in which every pair matches, with N = MAX_WIN included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Latches the configuration and begins a run |
| sample_vld | input | 1 | The sample bit is valid in this cycle |
| sample_bit | input | 1 | Raw sampled bit |
| lag_len | input | ceil(log2(MAX_LAG+1)) | Lag M in samples |
| win_len | input | ceil(log2(MAX_WIN+1)) | Comparisons per window, N |
| win_total | input | ceil(log2(MAX_RUN+1)) | Windows per run, K |
| match_count | output | ceil(log2(MAX_WIN+1)) | Match count of the last closed window |
| count_stb | output | 1 | One-cycle strobe marking a new count |
| run_done | output | 1 | The K-th window has completed |

## Verification
The bench sweeps lags, window sizes and window totals over a small configuration and feeds each combination four streams. A constant stream must give N in every window, which exposes any window-length or overflow error. An alternating stream matches only when M is even, so it separates an off-by-one lag from a correct one. A period-three stream and a pseudo-random stream give counts that differ from window to window, and these show whether the right pair of bits is compared. Runs with idle gaps, with configuration changes in the middle, with zero or over-range settings, and with a restart during a run check that the lag counts only accepted samples, that the latched settings hold, and that a start clears all run state.

// File: rtl/lsmc_pkg.sv
package lsmc_pkg;

  // Forces a configuration value into [1, hi].
  function automatic int unsigned cfg_clamp(int unsigned v, int unsigned hi);
    if (v == 0) return 1;
    if (v > hi) return hi;
    return v;
  endfunction

  // Returns 1 when the new bit equals the lagged bit.
  function automatic logic bits_agree(logic fresh, logic lagged);
    return ~(fresh ^ lagged);
  endfunction

endpackage

// File: rtl/lsmc_delay_line.sv
module lsmc_delay_line #(
  parameter int MAX_LAG = 2048,
  parameter int LAG_W   = $clog2(MAX_LAG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             din,
  input  logic [LAG_W-1:0] lag,
  output logic             tap,
  output logic             full
);

  logic [MAX_LAG-1:0] line;
  logic [LAG_W-1:0]   fill;

  generate
    if (MAX_LAG == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     line <= '0;
        else if (shift) line <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     line <= '0;
        else if (shift) line <= {line[MAX_LAG-2:0], din};
      end
    end
  endgenerate

  // Number of samples held since the last clear, saturating at the lag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fill <= '0;
    else if (clear)            fill <= '0;
    else if (shift && !full)   fill <= fill + LAG_W'(1);
  end

  assign full = (fill == lag);
  assign tap  = line[lag - LAG_W'(1)];

endmodule

// File: rtl/lsmc_window.sv
module lsmc_window #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cmp_vld,
  input  logic             match,
  input  logic [CNT_W-1:0] win_len,
  output logic [CNT_W-1:0] count_o,
  output logic             stb_o,
  output logic             close_o
);

  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] acc;

  assign close_o = cmp_vld && (pos == win_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      acc     <= '0;
      count_o <= '0;
      stb_o   <= 1'b0;
    end else if (clear) begin
      pos   <= '0;
      acc   <= '0;
      stb_o <= 1'b0;
    end else begin
      stb_o <= close_o;
      if (close_o) begin
        count_o <= acc + CNT_W'(match);
        pos     <= '0;
        acc     <= '0;
      end else if (cmp_vld) begin
        pos <= pos + CNT_W'(1);
        acc <= acc + CNT_W'(match);
      end
    end
  end

endmodule

// File: rtl/lsmc_run_ctrl.sv
module lsmc_run_ctrl #(
  parameter int MAX_LAG = 2048,
  parameter int MAX_WIN = 255,
  parameter int MAX_RUN = 65535,
  parameter int LAG_W   = $clog2(MAX_LAG + 1),
  parameter int CNT_W   = $clog2(MAX_WIN + 1),
  parameter int RUN_W   = $clog2(MAX_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAG_W-1:0] lag_in,
  input  logic [CNT_W-1:0] win_in,
  input  logic [RUN_W-1:0] run_in,
  input  logic             win_close,
  output logic [LAG_W-1:0] m_cfg,
  output logic [CNT_W-1:0] n_cfg,
  output logic             active,
  output logic             done
);

  logic [RUN_W-1:0] k_cfg;
  logic [RUN_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg  <= LAG_W'(1);
      n_cfg  <= CNT_W'(1);
      k_cfg  <= RUN_W'(1);
      idx    <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      m_cfg  <= LAG_W'(lsmc_pkg::cfg_clamp(32'(lag_in), MAX_LAG));
      n_cfg  <= CNT_W'(lsmc_pkg::cfg_clamp(32'(win_in), MAX_WIN));
      k_cfg  <= RUN_W'(lsmc_pkg::cfg_clamp(32'(run_in), MAX_RUN));
      idx    <= '0;
      active <= 1'b1;
      done   <= 1'b0;
    end else if (win_close) begin
      if (idx == k_cfg - RUN_W'(1)) begin
        active <= 1'b0;
        done   <= 1'b1;
      end else begin
        idx <= idx + RUN_W'(1);
      end
    end
  end

endmodule

// File: rtl/lag_match_counter.sv
module lag_match_counter #(
  parameter int MAX_LAG = 2048,
  parameter int MAX_WIN = 255,
  parameter int MAX_RUN = 65535,
  localparam int LAG_W  = $clog2(MAX_LAG + 1),
  localparam int CNT_W  = $clog2(MAX_WIN + 1),
  localparam int RUN_W  = $clog2(MAX_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sample_vld,
  input  logic             sample_bit,
  input  logic [LAG_W-1:0] lag_len,
  input  logic [CNT_W-1:0] win_len,
  input  logic [RUN_W-1:0] win_total,
  output logic [CNT_W-1:0] match_count,
  output logic             count_stb,
  output logic             run_done
);

  // Named internal events, observed by the bound checker.
  logic [LAG_W-1:0] m_cfg;
  logic [CNT_W-1:0] n_cfg;
  logic             active;
  logic             smp_take;
  logic             line_full;
  logic             lag_bit;
  logic             cmp_vld;
  logic             cmp_match;
  logic             win_close;

  assign smp_take  = active && sample_vld && !start;
  assign cmp_vld   = smp_take && line_full;
  assign cmp_match = lsmc_pkg::bits_agree(sample_bit, lag_bit);

  lsmc_run_ctrl #(
    .MAX_LAG(MAX_LAG), .MAX_WIN(MAX_WIN), .MAX_RUN(MAX_RUN),
    .LAG_W(LAG_W), .CNT_W(CNT_W), .RUN_W(RUN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lag_in(lag_len), .win_in(win_len), .run_in(win_total),
    .win_close(win_close),
    .m_cfg(m_cfg), .n_cfg(n_cfg), .active(active), .done(run_done)
  );

  lsmc_delay_line #(.MAX_LAG(MAX_LAG), .LAG_W(LAG_W)) u_line (
    .clk(clk), .rst_n(rst_n), .clear(start), .shift(smp_take),
    .din(sample_bit), .lag(m_cfg), .tap(lag_bit), .full(line_full)
  );

  lsmc_window #(.CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clear(start), .cmp_vld(cmp_vld),
    .match(cmp_match), .win_len(n_cfg),
    .count_o(match_count), .stb_o(count_stb), .close_o(win_close)
  );

endmodule

// File: rtl/lsmc_checker.sv
module lsmc_checker #(
  parameter int MAX_LAG = 2048,
  parameter int MAX_WIN = 255,
  localparam int LAG_W  = $clog2(MAX_LAG + 1),
  localparam int CNT_W  = $clog2(MAX_WIN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             smp_take,
  input logic             cmp_vld,
  input logic             count_stb,
  input logic             run_done,
  input logic [CNT_W-1:0] match_count,
  input logic [LAG_W-1:0] m_cfg,
  input logic [CNT_W-1:0] n_cfg
);

  // Independent count of samples taken since the last start.
  int unsigned seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              seen <= 0;
    else if (start)                          seen <= 0;
    else if (smp_take && seen < MAX_LAG)     seen <= seen + 1;
  end

  a_r2_fill_first: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld |-> (seen >= 32'(m_cfg)));

  a_r5_stb_follows_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    count_stb |-> $past(cmp_vld));

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_stb |-> (match_count <= n_cfg));

  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done && !start) |=> run_done);

  a_r6_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done && !start) |=> !count_stb);

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!run_done && !count_stb));

  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(m_cfg) && $stable(n_cfg)));

endmodule

bind lag_match_counter lsmc_checker #(.MAX_LAG(MAX_LAG), .MAX_WIN(MAX_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .smp_take(smp_take),
  .cmp_vld(cmp_vld), .count_stb(count_stb), .run_done(run_done),
  .match_count(match_count), .m_cfg(m_cfg), .n_cfg(n_cfg)
);

// File: tb/test_lag_match_counter.sv
module test_lag_match_counter;

  localparam int MAX_LAG = 16;
  localparam int MAX_WIN = 15;
  localparam int MAX_RUN = 7;
  localparam int LAG_W = $clog2(MAX_LAG + 1);
  localparam int CNT_W = $clog2(MAX_WIN + 1);
  localparam int RUN_W = $clog2(MAX_RUN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sample_vld = 1'b0;
  logic sample_bit = 1'b0;
  logic [LAG_W-1:0] lag_len = '0;
  logic [CNT_W-1:0] win_len = '0;
  logic [RUN_W-1:0] win_total = '0;
  logic [CNT_W-1:0] match_count;
  logic count_stb;
  logic run_done;

  always #10 clk = ~clk;  // 50 MHz

  lag_match_counter #(.MAX_LAG(MAX_LAG), .MAX_WIN(MAX_WIN), .MAX_RUN(MAX_RUN))
    i_lag_match_counter (
      .clk(clk), .rst_n(rst_n), .start(start), .sample_vld(sample_vld),
      .sample_bit(sample_bit), .lag_len(lag_len), .win_len(win_len),
      .win_total(win_total), .match_count(match_count),
      .count_stb(count_stb), .run_done(run_done));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  // Bench model state
  int hist [512];
  int m_s, m_wpos, m_wacc, m_widx;
  bit m_done;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(int v, int hi);
    if (v == 0) return 1;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int pattern_bit(int kind, int i);
    case (kind)
      0: return 1;
      1: return i % 2;
      2: return (i % 3 == 0) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  // kind 3 uses the LFSR; gap: every third cycle has sample_vld low (R4)
  task automatic run_case(int mi, int ni, int ki, int kind, bit gap, int cyc_override);
    int me, ne, ke, cycles, i;
    bit exp_stb;
    int exp_cnt;
    me = eff(mi, MAX_LAG);
    ne = eff(ni, MAX_WIN);
    ke = eff(ki, MAX_RUN);
    cycles = (cyc_override > 0) ? cyc_override : 2 * (me + ne * ke) + 12;
    @(negedge clk);
    lag_len = LAG_W'(mi);
    win_len = CNT_W'(ni);
    win_total = RUN_W'(ki);
    start = 1'b1;
    sample_vld = 1'b1;  // dropped because start has priority (R7)
    sample_bit = 1'b1;
    @(posedge clk);
    #5;
    check(run_done == 1'b0, "R7 done cleared by start", int'(run_done), 0);
    check(count_stb == 1'b0, "R7 no strobe after start", int'(count_stb), 0);
    m_s = 0; m_wpos = 0; m_wacc = 0; m_widx = 0; m_done = 1'b0;
    i = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      start = 1'b0;
      // R8: scramble the configuration inputs during the run
      lag_len = LAG_W'(c * 7 + 3);
      win_len = CNT_W'(c * 5 + 1);
      win_total = RUN_W'(c + 2);
      exp_stb = 1'b0;
      exp_cnt = 0;
      if (gap && (c % 3 == 2)) begin
        sample_vld = 1'b0;
        sample_bit = ~sample_bit;
      end else begin
        int b;
        if (kind == 3) begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          b = int'(lfsr[0]);
        end else begin
          b = pattern_bit(kind, i);
        end
        i++;
        sample_vld = 1'b1;
        sample_bit = b[0];
        if (!m_done && m_s < 512) begin
          if (m_s >= me) begin
            if (hist[m_s - me] == b) m_wacc++;
            m_wpos++;
            if (m_wpos == ne) begin
              exp_stb = 1'b1;
              exp_cnt = m_wacc;
              m_wpos = 0;
              m_wacc = 0;
              m_widx++;
              if (m_widx == ke) m_done = 1'b1;
            end
          end
          hist[m_s] = b;
          m_s++;
        end
      end
      @(posedge clk);
      #5;
      check(count_stb == exp_stb, "R2/R4/R5 strobe timing", int'(count_stb), int'(exp_stb));
      if (exp_stb && count_stb)
        check(int'(match_count) == exp_cnt, "R3 window count", int'(match_count), exp_cnt);
      check(run_done == m_done, "R6 done flag", int'(run_done), int'(m_done));
    end
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lags [5] = '{1, 2, 3, 5, 16};
    int wins [3] = '{1, 3, 15};
    repeat (3) @(posedge clk);
    #5;
    check(count_stb == 1'b0, "R1 reset strobe", int'(count_stb), 0);
    check(run_done == 1'b0, "R1 reset done", int'(run_done), 0);
    check(match_count == '0, "R1 reset count", int'(match_count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: samples without a start give no strobe
    sample_vld = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      sample_bit = c[0];
      @(posedge clk);
      #5;
      check(count_stb == 1'b0, "R1 idle before start", int'(count_stb), 0);
    end
    sample_vld = 1'b0;

    for (int a = 0; a < 5; a++)
      for (int w = 0; w < 3; w++)
        for (int k = 1; k <= 3; k += 2)
          for (int p = 0; p < 4; p++)
            run_case(lags[a], wins[w], k, p, (p + a) % 2 == 1, 0);

    // R10: full window at MAX_WIN, all matches
    run_case(4, MAX_WIN, 2, 0, 1'b0, 0);
    // R9: zero settings and an over-range lag
    run_case(0, 0, 0, 3, 1'b0, 0);
    run_case(31, 2, 2, 3, 1'b1, 0);
    run_case(5, 4, 0, 1, 1'b0, 0);
    // R7: restart in the middle of a run, then a full run
    run_case(6, 4, 5, 3, 1'b0, 12);
    run_case(6, 4, 3, 2, 1'b1, 0);
    run_case(2, 3, MAX_RUN, 3, 1'b0, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule